// File: doc/BRIEF.md
# Pipelined Complex Multiplier with Output View Select

This block multiplies two complex operands, each made of a 16-bit two's complement real part and a 16-bit two's complement imaginary part, and produces the full-width 32-bit real and imaginary parts of the product. The operands are captured in a register stage. The four real partial products are registered in a second stage, and the add/subtract combination is registered in a third. A valid flag travels through the pipeline next to the data. The one sum that can exceed the 32-bit signed range clamps to the largest positive value instead of wrapping.

Two 16-bit output buses carry a view of the most recent result. A 2-bit select chooses the view and is not registered, so a change on it reaches the buses in the same cycle. Two views show the complex result, using either the upper or the lower half-words of both parts. The other two views spread one full 32-bit part across both buses. When the block-floating-point mode input is high, the block ignores the select and always shows the upper-half complex view.

Top module: `cmplx_mul_sel`

## Requirements
- R1: While reset (rstN low) is asserted, outValid is 0 and both buses read 0. The buses stay 0 after reset until the first result arrives.
- R2: For operands A and B, the result real part equals Are*Bre - Aim*Bim and the imaginary part equals Are*Bim + Aim*Bre. Both are 32-bit two's complement values.
- R3: A sum above 2^31-1 reads as 32'h7FFFFFFF and a sum below -2^31 reads as 32'h80000000. The all -32768 operand pair therefore gives imaginary 32'h7FFFFFFF and real 0.
- R4: Operands presented with inValid high at a rising edge produce their result, and outValid is high, after the third rising edge counted from that one.
- R5: With outSel = 2'b00, busRe carries real[31:16] and busIm carries imag[31:16].
- R6: With outSel = 2'b01, busRe carries real[15:0] and busIm carries imag[15:0].
- R7: With outSel = 2'b10, busRe carries real[31:16] and busIm carries real[15:0].
- R8: With outSel = 2'b11, busRe carries imag[31:16] and busIm carries imag[15:0].
- R9: The select is combinational. A change on outSel changes the buses without any clock edge.
- R10: While bfpMode is 1, the buses show the outSel = 2'b00 view whatever value outSel has.
- R11: A cycle with inValid low produces a cycle with outValid low three edges later. The held result, and so the buses for a fixed select, do not change.
- R12: Operands may arrive on every cycle, and each one yields its own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands on the inputs are to be taken at this edge |
| aRe | input | 16 | Operand A real part, two's complement |
| aIm | input | 16 | Operand A imaginary part, two's complement |
| bRe | input | 16 | Operand B real part, two's complement |
| bIm | input | 16 | Operand B imaginary part, two's complement |
| bfpMode | input | 1 | Block-floating-point mode: forces the upper-half complex view |
| outSel | input | 2 | Output view select, not registered |
| outValid | output | 1 | A new result reached the output stage at the last edge |
| busRe | output | 16 | First output bus |
| busIm | output | 16 | Second output bus |

## Verification
The bench builds the block with its default operand width of 16, so the product parts are 32 bits wide. At this width the all -32768 operand pair is the only input that overflows. The bench applies it as a directed case and also mixes it into the random stream. Random operands, valid gaps, select changes and mode flips are compared on every cycle against a behavioural model. Separate steps change the select between edges to expose the combinational path, and hold the inputs idle to show that results are retained.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // Output view codes; the numeric values are part of the block's interface.
  typedef enum logic [1:0] {
    SEL_CPX_HI = 2'b00,
    SEL_CPX_LO = 2'b01,
    SEL_REAL   = 2'b10,
    SEL_IMAG   = 2'b11
  } outSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    loadOp;
    logic    loadProd;
    logic    loadSum;
    outSel_e view;
  } cmulStrobes_t;

endpackage

// File: rtl/cmul_ctrl.sv
module cmul_ctrl
  import cmul_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         bfpMode,
  input  logic [1:0]   outSel,
  output cmulStrobes_t strb,
  output logic         outValid
);

  logic opValid;
  logic prodValid;
  logic sumValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opValid   <= 1'b0;
      prodValid <= 1'b0;
      sumValid  <= 1'b0;
    end else begin
      opValid   <= inValid;
      prodValid <= opValid;
      sumValid  <= prodValid;
    end
  end

  always_comb begin
    strb.loadOp   = inValid;
    strb.loadProd = opValid;
    strb.loadSum  = prodValid;
    // Block-floating-point mode pins the view to the upper complex halves.
    strb.view     = bfpMode ? SEL_CPX_HI : outSel_e'(outSel);
  end

  assign outValid = sumValid;

endmodule

// File: rtl/cmul_datapath.sv
module cmul_datapath
  import cmul_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  cmulStrobes_t       strb,
  input  logic signed [OP_W-1:0] aRe,
  input  logic signed [OP_W-1:0] aIm,
  input  logic signed [OP_W-1:0] bRe,
  input  logic signed [OP_W-1:0] bIm,
  output logic [2*OP_W-1:0]  resRe,
  output logic [2*OP_W-1:0]  resIm,
  output logic [OP_W-1:0]    busRe,
  output logic [OP_W-1:0]    busIm
);

  localparam int RES_W  = 2 * OP_W;
  localparam int SUM_W  = RES_W + 1;
  localparam int N_PROD = 4;

  // Operand stage: index 0 = A real, 1 = A imag, 2 = B real, 3 = B imag.
  logic signed [OP_W-1:0] opQ [4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) opQ[i] <= '0;
    end else if (strb.loadOp) begin
      opQ[0] <= aRe;
      opQ[1] <= aIm;
      opQ[2] <= bRe;
      opQ[3] <= bIm;
    end
  end

  // Partial products: 0 = ArBr, 1 = AiBi, 2 = ArBi, 3 = AiBr.
  logic signed [RES_W-1:0] prodQ [N_PROD];

  for (genvar g = 0; g < N_PROD; g++) begin : g_prod
    localparam int LHS = (g == 0 || g == 2) ? 0 : 1;
    localparam int RHS = (g == 0 || g == 3) ? 2 : 3;
    logic signed [RES_W-1:0] prodD;
    assign prodD = opQ[LHS] * opQ[RHS];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              prodQ[g] <= '0;
      else if (strb.loadProd) prodQ[g] <= prodD;
    end
  end

  function automatic logic [RES_W-1:0] clampSum(input logic [SUM_W-1:0] s);
    if (s[SUM_W-1] != s[SUM_W-2])
      clampSum = s[SUM_W-1] ? {1'b1, {(RES_W-1){1'b0}}} : {1'b0, {(RES_W-1){1'b1}}};
    else
      clampSum = s[RES_W-1:0];
  endfunction

  logic signed [SUM_W-1:0] sumRe;
  logic signed [SUM_W-1:0] sumIm;

  always_comb begin
    sumRe = SUM_W'(prodQ[0]) - SUM_W'(prodQ[1]);
    sumIm = SUM_W'(prodQ[2]) + SUM_W'(prodQ[3]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resRe <= '0;
      resIm <= '0;
    end else if (strb.loadSum) begin
      resRe <= clampSum(sumRe);
      resIm <= clampSum(sumIm);
    end
  end

  // Unregistered view select.
  always_comb begin
    unique case (strb.view)
      SEL_CPX_HI: begin busRe = resRe[RES_W-1:OP_W]; busIm = resIm[RES_W-1:OP_W]; end
      SEL_CPX_LO: begin busRe = resRe[OP_W-1:0];     busIm = resIm[OP_W-1:0];     end
      SEL_REAL:   begin busRe = resRe[RES_W-1:OP_W]; busIm = resRe[OP_W-1:0];     end
      SEL_IMAG:   begin busRe = resIm[RES_W-1:OP_W]; busIm = resIm[OP_W-1:0];     end
      default:    begin busRe = '0;                  busIm = '0;                  end
    endcase
  end

endmodule

// File: rtl/cmplx_mul_sel.sv
module cmplx_mul_sel
  import cmul_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic signed [OP_W-1:0] aRe,
  input  logic signed [OP_W-1:0] aIm,
  input  logic signed [OP_W-1:0] bRe,
  input  logic signed [OP_W-1:0] bIm,
  input  logic                   bfpMode,
  input  logic [1:0]             outSel,
  output logic                   outValid,
  output logic [OP_W-1:0]        busRe,
  output logic [OP_W-1:0]        busIm
);

  cmulStrobes_t         strb;
  logic [2*OP_W-1:0]    resRe;
  logic [2*OP_W-1:0]    resIm;

  cmul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .bfpMode  (bfpMode),
    .outSel   (outSel),
    .strb     (strb),
    .outValid (outValid)
  );

  cmul_datapath #(.OP_W(OP_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .aRe   (aRe),
    .aIm   (aIm),
    .bRe   (bRe),
    .bIm   (bIm),
    .resRe (resRe),
    .resIm (resIm),
    .busRe (busRe),
    .busIm (busIm)
  );

endmodule

// File: rtl/cmul_checker.sv
module cmul_checker #(
  parameter int OP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              bfpMode,
  input logic [1:0]        outSel,
  input logic              outValid,
  input logic [OP_W-1:0]   busRe,
  input logic [OP_W-1:0]   busIm,
  input logic [2*OP_W-1:0] resRe,
  input logic [2*OP_W-1:0] resIm
);

  localparam int RES_W = 2 * OP_W;

  // Edges since reset release, saturating at 3, so $past never reaches before reset.
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3) |-> (outValid == $past(inValid, 3)));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd3 && !$past(inValid, 3)) |-> ($stable(resRe) && $stable(resIm)));

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (resIm != {1'b1, {(RES_W-1){1'b0}}}));

  assert_bfp_forces_hi_R10: assert property (@(posedge clk) disable iff (!rstN)
    bfpMode |-> (busRe == resRe[RES_W-1:OP_W] && busIm == resIm[RES_W-1:OP_W]));

  assert_real_view_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!bfpMode && outSel == 2'b10) |-> ({busRe, busIm} == resRe));

endmodule

bind cmplx_mul_sel cmul_checker #(.OP_W(OP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .bfpMode  (bfpMode),
  .outSel   (outSel),
  .outValid (outValid),
  .busRe    (busRe),
  .busIm    (busIm),
  .resRe    (resRe),
  .resIm    (resIm)
);

// File: tb/sim_cmplx_mul_sel.sv
module sim_cmplx_mul_sel;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [15:0] aRe = '0, aIm = '0, bRe = '0, bIm = '0;
  logic bfpMode = 1'b0;
  logic [1:0] outSel = 2'b00;
  logic outValid;
  logic [15:0] busRe, busIm;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmplx_mul_sel u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .bfpMode(bfpMode), .outSel(outSel),
    .outValid(outValid), .busRe(busRe), .busIm(busIm)
  );

  // Behavioural reference: three pipeline slots and the held result.
  bit          mV  [3] = '{0, 0, 0};
  logic [31:0] mRe [3] = '{0, 0, 0};
  logic [31:0] mIm [3] = '{0, 0, 0};
  logic [31:0] heldRe = '0, heldIm = '0;

  function automatic logic [31:0] clamp32(input longint v);
    if (v > 64'sd2147483647)  return 32'h7FFF_FFFF;
    if (v < -64'sd2147483648) return 32'h8000_0000;
    return v[31:0];
  endfunction

  function automatic logic [31:0] viewOf(input logic [31:0] r, input logic [31:0] i,
                                         input logic [1:0] s, input logic bfp);
    logic [1:0] e;
    e = bfp ? 2'b00 : s;
    case (e)
      2'b00:   return {r[31:16], i[31:16]};
      2'b01:   return {r[15:0],  i[15:0]};
      2'b10:   return r;
      default: return i;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 3; k++) begin mV[k] = 0; mRe[k] = '0; mIm[k] = '0; end
      heldRe = '0; heldIm = '0;
    end else begin
      mV[2] = mV[1]; mRe[2] = mRe[1]; mIm[2] = mIm[1];
      if (mV[2]) begin heldRe = mRe[2]; heldIm = mIm[2]; end
      mV[1] = mV[0]; mRe[1] = mRe[0]; mIm[1] = mIm[0];
      mV[0] = inValid;
      mRe[0] = clamp32(longint'(aRe) * longint'(bRe) - longint'(aIm) * longint'(bIm));
      mIm[0] = clamp32(longint'(aRe) * longint'(bIm) + longint'(aIm) * longint'(bRe));
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (running) begin
      string tag;
      if (!rstN) tag = "R1";
      else if (bfpMode) tag = "R10";
      else case (outSel)
        2'b00: tag = "R5";
        2'b01: tag = "R6";
        2'b10: tag = "R7";
        default: tag = "R8";
      endcase
      chk("R4 R12 outValid", {31'd0, outValid}, {31'd0, mV[2]});
      chk(tag, {busRe, busIm}, viewOf(heldRe, heldIm, outSel, bfpMode));
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic sendOne(input logic signed [15:0] ar, input logic signed [15:0] ai,
                         input logic signed [15:0] br, input logic signed [15:0] bi);
    @(negedge clk);
    aRe = ar; aIm = ai; bRe = br; bIm = bi; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    running = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid in reset", {31'd0, outValid}, 32'd0);
    chk("R1 buses in reset", {busRe, busIm}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 buses after reset", {busRe, busIm}, 32'd0);

    // R2: (3+4i)(5-2i) = 23 + 14i
    outSel = 2'b10;
    sendOne(16'sd3, 16'sd4, 16'sd5, -16'sd2);
    chk("R2 real part", {busRe, busIm}, 32'd23);
    outSel = 2'b11;
    #1 chk("R2 imag part", {busRe, busIm}, 32'd14);

    // R3: all -32768 operands saturate the imaginary part
    sendOne(-16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768);
    chk("R3 imag clamps", {busRe, busIm}, 32'h7FFF_FFFF);
    outSel = 2'b10;
    #1 chk("R3 real is zero", {busRe, busIm}, 32'd0);

    // R9: view changes with no clock edge; R11: held while idle
    sendOne(16'sh7FFF, -16'sd12345, 16'sd321, 16'sh4000);
    outSel = 2'b01;
    #1 chk("R9 lo view same cycle", {busRe, busIm},
           {16'(32'sd32767 * 321 + 32'sd12345 * 16384), 16'(32'sd32767 * 16384 - 32'sd12345 * 321)});
    outSel = 2'b11;
    #1 chk("R9 imag view same cycle", {busRe, busIm}, 32'(32'sd32767 * 16384 - 32'sd12345 * 321));
    repeat (5) @(negedge clk);
    chk("R11 result held while idle", {busRe, busIm}, 32'(32'sd32767 * 16384 - 32'sd12345 * 321));
    bfpMode = 1'b1;
    #1 chk("R10 bfp forces hi view", {busRe, busIm},
           {16'((32'sd32767 * 321 + 32'sd12345 * 16384) >>> 16),
            16'((32'sd32767 * 16384 - 32'sd12345 * 321) >>> 16)});
    bfpMode = 1'b0;

    // Random stream: back-to-back and gapped operands (R12), all views and modes
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      inValid = (n < 200) ? 1'b1 : ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 15) == 0) begin
        aRe = -16'sd32768; aIm = -16'sd32768; bRe = -16'sd32768; bIm = -16'sd32768;
      end else begin
        aRe = 16'($urandom); aIm = 16'($urandom); bRe = 16'($urandom); bIm = 16'($urandom);
      end
      outSel  = 2'($urandom);
      bfpMode = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (6) @(negedge clk);
    running = 1'b0;
    finishRun();
  end

endmodule